// File: doc/BRIEF.md
# Keypad Row Latch Unit

This unit is the register-bus front end for a key matrix of 5 rows and 8 columns. Software selects which columns are driven by writing a column-drive register in which a 0 bit selects a column. Each clock the unit forms a 5-bit row latch: a row's bit is cleared when any key in that row is pressed in a selected column, and is set otherwise. With nothing pressed, the latch rests at all ones (0x1F).

The keyboard interrupt is a level signal. It is high while the row latch differs from its idle value, the one-bit keyboard mask is clear and the functional-clock enable input is high. It falls again when the keys are released, when the columns are reprogrammed to deselect the pressed keys, when the mask is set or when the clock enable drops. Software reads the row latch, the column register, a pending-status bit and the mask over a 16-bit bus with byte offsets.

Top module: `kbd_row_latch_unit`

## Requirements
- R1: After a synchronous reset the row latch reads 0x1F, the column register reads 0x00, the mask reads 0, the status reads 0 and `kbd_irq` is low.
- R2: Row latch bit r reads 0 when some key at index r*8+c of `key_pressed` is 1 and bit c of the column register is 0; otherwise bit r reads 1. Several rows and several columns combine independently.
- R3: A write to offset 0x14 stores `bus_wdata[7:0]` into the column register. Reading 0x14 returns that value with bits 15:8 equal to 0.
- R4: A write to offset 0x28 stores `bus_wdata[0]` as the mask. Reading 0x28 returns the mask in bit 0 and zeros above it.
- R5: Reading offset 0x20 returns 1 in bit 0 exactly when the row latch differs from 0x1F and the mask is 0. It returns 0 otherwise, and bits 15:1 are always 0.
- R6: `kbd_irq` is high exactly when the status of R5 is 1 and `fclk_en` is high.
- R7: Writes to offset 0x10 (row latch), to offset 0x20 (status) and to any unmapped offset change no state. Reads from unmapped offsets return 0.
- R8: The row latch is sampled on every clock edge from the current key inputs and the column register, whatever the level of `fclk_en`. A key change or a column write is therefore visible in the latch one clock after the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fclk_en | input | 1 | Functional-clock enable; gates the interrupt |
| bus_wr | input | 1 | Write strobe for the current bus address |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| key_pressed | input | 40 | Key states, row-major, 8 bits per row, 1 = pressed |
| kbd_irq | output | 1 | Level keyboard interrupt |

## Verification
The row function is tried with a single key under all columns driven, the same key with its own column deselected and then as the only selected column, and keys in the outer rows combined with partial column masks. Together these show whether the column polarity is right, whether rows are kept apart, and whether key index and column bit are paired correctly. The mask and clock-enable patterns separate the status bit from the interrupt pin. Writes to read-only and unmapped offsets, and wide data words, show that decoding and field widths are tight.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    localparam int unsigned KP_ROWS   = 5;
    localparam int unsigned KP_COLS   = 8;
    localparam int unsigned KP_BUS_W  = 16;
    localparam int unsigned KP_ADDR_W = 8;

    localparam logic [KP_ADDR_W-1:0] OFS_ROWS = 8'h10;
    localparam logic [KP_ADDR_W-1:0] OFS_COLS = 8'h14;
    localparam logic [KP_ADDR_W-1:0] OFS_STAT = 8'h20;
    localparam logic [KP_ADDR_W-1:0] OFS_MASK = 8'h28;

    typedef enum logic [2:0] {
        SEL_ROWS,
        SEL_COLS,
        SEL_STAT,
        SEL_MASK,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic                 wr;
        logic [KP_ADDR_W-1:0] addr;
        logic [KP_BUS_W-1:0]  wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_sel(input logic [KP_ADDR_W-1:0] a);
        case (a)
            OFS_ROWS: decode_sel = SEL_ROWS;
            OFS_COLS: decode_sel = SEL_COLS;
            OFS_STAT: decode_sel = SEL_STAT;
            OFS_MASK: decode_sel = SEL_MASK;
            default:  decode_sel = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/kbd_ctl_regs.sv
module kbd_ctl_regs
    import kbd_pkg::*;
#(
    parameter int unsigned COLS = KP_COLS
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_req_t        req,
    output logic [COLS-1:0] col_q,
    output logic            mask_q
);

    reg_sel_e sel;
    logic     col_we;
    logic     mask_we;

    always_comb begin
        sel     = decode_sel(req.addr);
        col_we  = req.wr && (sel == SEL_COLS);
        mask_we = req.wr && (sel == SEL_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            mask_q <= 1'b0;
        end else begin
            if (col_we)  col_q  <= req.wdata[COLS-1:0];
            if (mask_we) mask_q <= req.wdata[0];
        end
    end

    // R3
    col_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.addr == OFS_COLS) |=> $stable(col_q));

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.addr == OFS_MASK) |=> $stable(mask_q));

endmodule

// File: rtl/kbd_row_sampler.sv
module kbd_row_sampler #(
    parameter int unsigned ROWS = kbd_pkg::KP_ROWS,
    parameter int unsigned COLS = kbd_pkg::KP_COLS,
    localparam int unsigned KEYS = ROWS * COLS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [KEYS-1:0] key_pressed,
    input  logic [COLS-1:0] col_q,
    output logic [ROWS-1:0] row_q
);

    logic [ROWS-1:0] row_hit;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_hit[r] = |(key_pressed[r*COLS +: COLS] & ~col_q);

        always_ff @(posedge clk) begin
            if (rst) row_q[r] <= 1'b1;
            else     row_q[r] <= ~row_hit[r];
        end
    end

    // R1
    row_reset_chk: assert property (@(posedge clk)
        rst |=> (row_q == '1));

    // R2
    row_idle_when_undriven_chk: assert property (@(posedge clk) disable iff (rst)
        (col_q == '1) |=> (row_q == '1));

    // R8
    row_idle_when_released_chk: assert property (@(posedge clk) disable iff (rst)
        (key_pressed == '0) |=> (row_q == '1));

endmodule

// File: rtl/kbd_read_mux.sv
module kbd_read_mux
    import kbd_pkg::*;
#(
    parameter int unsigned ROWS  = KP_ROWS,
    parameter int unsigned COLS  = KP_COLS,
    parameter int unsigned BUS_W = KP_BUS_W
) (
    input  logic [KP_ADDR_W-1:0] addr,
    input  logic [ROWS-1:0]      row_q,
    input  logic [COLS-1:0]      col_q,
    input  logic                 mask_q,
    input  logic                 pending,
    output logic [BUS_W-1:0]     rdata
);

    always_comb begin
        rdata = '0;
        case (decode_sel(addr))
            SEL_ROWS: rdata[ROWS-1:0] = row_q;
            SEL_COLS: rdata[COLS-1:0] = col_q;
            SEL_STAT: rdata[0]        = pending;
            SEL_MASK: rdata[0]        = mask_q;
            default:  rdata           = '0;
        endcase
    end

endmodule

// File: rtl/kbd_row_latch_unit.sv
module kbd_row_latch_unit
    import kbd_pkg::*;
#(
    parameter int unsigned ROWS  = KP_ROWS,
    parameter int unsigned COLS  = KP_COLS,
    parameter int unsigned BUS_W = KP_BUS_W,
    localparam int unsigned KEYS = ROWS * COLS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fclk_en,
    input  logic                 bus_wr,
    input  logic [KP_ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [KEYS-1:0]      key_pressed,
    output logic                 kbd_irq
);

    bus_req_t        req;
    logic [COLS-1:0] col_q;
    logic            mask_q;
    logic [ROWS-1:0] row_q;
    logic            pending;

    always_comb begin
        req.wr    = bus_wr;
        req.addr  = bus_addr;
        req.wdata = KP_BUS_W'(bus_wdata);
    end

    kbd_ctl_regs #(.COLS(COLS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .col_q  (col_q),
        .mask_q (mask_q)
    );

    kbd_row_sampler #(.ROWS(ROWS), .COLS(COLS)) u_rows (
        .clk         (clk),
        .rst         (rst),
        .key_pressed (key_pressed),
        .col_q       (col_q),
        .row_q       (row_q)
    );

    assign pending = (row_q != '1) && !mask_q;
    assign kbd_irq = pending && fclk_en;

    kbd_read_mux #(.ROWS(ROWS), .COLS(COLS), .BUS_W(BUS_W)) u_rd (
        .addr    (bus_addr),
        .row_q   (row_q),
        .col_q   (col_q),
        .mask_q  (mask_q),
        .pending (pending),
        .rdata   (bus_rdata)
    );

    // R6
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        kbd_irq |-> fclk_en);

    // R5
    irq_blocked_by_mask_chk: assert property (@(posedge clk) disable iff (rst)
        kbd_irq |-> !mask_q);

    // R5
    irq_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
        kbd_irq |-> (row_q != '1));

endmodule

// File: tb/kbd_row_latch_unit_bench.sv
module kbd_row_latch_unit_bench;

    localparam int NR = 5;
    localparam int NC = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        fclk_en;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [39:0] key_pressed;
    logic        kbd_irq;

    always #10 clk = ~clk;

    kbd_row_latch_unit u_kbd_row_latch_unit (
        .clk         (clk),
        .rst         (rst),
        .fclk_en     (fclk_en),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .key_pressed (key_pressed),
        .kbd_irq     (kbd_irq)
    );

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 0;
    string tag = "R1";

    int         m_col;
    int         m_mask;
    logic [4:0] m_row;

    function automatic logic [4:0] ref_rows(logic [39:0] k, int col);
        logic [4:0] res = 5'h1F;
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                if (k[r*NC+c] && ((col >> c) & 1) == 0) res[r] = 1'b0;
        return res;
    endfunction

    function automatic int m_status();
        return (m_row != 5'h1F && m_mask == 0) ? 1 : 0;
    endfunction

    function automatic int ref_read(int a);
        case (a)
            'h10: return int'(m_row);
            'h14: return m_col;
            'h20: return m_status();
            'h28: return m_mask;
            default: return 0;
        endcase
    endfunction

    task automatic tick();
        logic [4:0] nrow;
        int exp_rd;
        int exp_irq;
        @(posedge clk);
        if (rst) begin
            m_col = 0; m_mask = 0; m_row = 5'h1F;
        end else begin
            nrow = ref_rows(key_pressed, m_col);
            if (bus_wr && bus_addr == 8'h14) m_col = int'(bus_wdata) & 'hFF;
            if (bus_wr && bus_addr == 8'h28) m_mask = int'(bus_wdata) & 1;
            m_row = nrow;
        end
        @(negedge clk);
        vectors++;
        exp_rd  = ref_read(int'(bus_addr));
        exp_irq = (m_status() == 1 && fclk_en) ? 1 : 0;
        if (int'(bus_rdata) != exp_rd) begin
            miscompares++;
            $display("FAIL %s: rdata @%h actual %h expected %h", tag, bus_addr, bus_rdata, exp_rd[15:0]);
        end
        if (int'(kbd_irq) != exp_irq) begin
            miscompares++;
            $display("FAIL %s: kbd_irq actual %0d expected %0d", tag, kbd_irq, exp_irq);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_wdata = 16'h0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a;
        tick();
    endtask

    task automatic rd_all();
        rd(8'h10); rd(8'h14); rd(8'h20); rd(8'h28);
    endtask

    task automatic press(input int r, input int c, input bit v);
        key_pressed[r*NC+c] = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fclk_en = 1'b1; bus_wr = 1'b0; bus_addr = 8'h10;
        bus_wdata = 16'h0; key_pressed = '0;
        tick(); tick();
        rst = 1'b0;
        tag = "R1"; rd_all();

        tag = "R2"; press(2, 3, 1); rd(8'h10); rd(8'h10); rd(8'h20);
        tag = "R6"; rd(8'h20);

        tag = "R8"; wr(8'h14, 16'h0008); rd(8'h10); rd(8'h10);
        tag = "R2"; wr(8'h14, 16'h00F7); rd(8'h10); rd(8'h10);

        tag = "R2";
        press(2, 3, 0); press(0, 7, 1); press(4, 0, 1); press(4, 6, 1);
        wr(8'h14, 16'h007F); rd(8'h10); rd(8'h10);
        wr(8'h14, 16'h00FE); rd(8'h10); rd(8'h10);
        wr(8'h14, 16'h00BF); rd(8'h10); rd(8'h10);
        wr(8'h14, 16'h0000); rd(8'h10); rd(8'h10);

        tag = "R4"; wr(8'h28, 16'h0001); rd(8'h28); rd(8'h20);
        tag = "R5"; rd(8'h20); rd(8'h10);
        tag = "R4"; wr(8'h28, 16'hFFFE); rd(8'h28); rd(8'h20);

        tag = "R6"; fclk_en = 1'b0; rd(8'h20); rd(8'h20);
        tag = "R8"; press(1, 1, 1); rd(8'h10); rd(8'h10);
        fclk_en = 1'b1; tag = "R6"; rd(8'h20);

        tag = "R7";
        wr(8'h10, 16'h0000); rd_all();
        wr(8'h20, 16'hFFFF); rd_all();
        wr(8'h3C, 16'hFFFF); rd(8'h3C); rd_all();
        wr(8'h15, 16'h00FF); rd_all();

        tag = "R3"; wr(8'h14, 16'hABCD); rd(8'h14); rd(8'h10);

        tag = "R5"; key_pressed = '0; rd(8'h20); rd(8'h20); rd(8'h10);

        tag = "R1"; rst = 1'b1; tick(); rst = 1'b0; rd_all();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule